// File: doc/BRIEF.md
# Configurable Digital Input Noise Filter

This block cleans up one asynchronous input pin before a timer uses it as an event source. The pin is first brought into the clock domain. It is then sampled at a rate taken from a small divider of the system clock. The filtered level changes only after a programmed number of consecutive samples all disagree with the current filtered level. Short glitches are therefore dropped, and real transitions appear with a known, bounded delay. Each accepted transition gives a one-clock rising or falling pulse, which a downstream counter can use directly.

Software sets the filter through one 8-bit control register. The register can be written as a whole byte or one bit at a time. Field positions are bit 6 for the sample count and bits 2:0 for the sample-rate code. Any write to the register counts as a reconfiguration. After such a write, a settled flag stays low for one full qualification interval, so software knows when the output can be trusted again. If a rate code is not supported, the block runs at full rate and raises a sticky error output.

Top module: `pin_noise_filter`

## Requirements
- R1: While `rst` is high, `bus_rdata` reads 0x00, `filt_level`, `rise_pulse`, `fall_pulse` and `cfg_error` are 0, and `settled` is 0. After reset is released, `settled` rises at the third rising clock edge with `rst` low (full rate, 3 samples).
- R2: A byte write (`bus_wr`=1) stores `bus_wdata[6]` and `bus_wdata[2:0]`. Bits 7 and 5:3 always read 0, and writes to them have no effect, so writing 0xFF reads back 0x47. A byte write takes priority over a bit write in the same cycle.
- R3: A bit write (`bus_bit_wr`=1, `bus_wr`=0) copies `bus_wdata[0]` into the bit numbered `bus_bit_sel` and leaves every other bit unchanged. A bit write to a reserved bit changes nothing.
- R4: Bit 6 sets the sample count N. A value of 0 gives N=3 and a value of 1 gives N=2.
- R5: Bits 2:0 set the sampling period P in clock cycles: 0→1, 1→2, 2→4, 3→16, 4→32, 5→64.
- R6: Codes 6 and 7 in bits 2:0 read back as written but sample at full rate (P=1). Any write that leaves such a code in the register sets `cfg_error`, and `cfg_error` stays set until reset.
- R7: A write that touches bits 2:0 restarts the sample divider, so the first sample is taken P cycles after the write edge.
- R8: A pulse on `pin_raw` lasting P×(N−1) clock cycles or less never changes `filt_level`.
- R9: The pin passes through two synchronizer flops. Suppose a write happens at edge E, `pin_raw` changes before edge E+1, and then holds. `filt_level` takes the new value at edge E + P·⌈3/P⌉ + (N−1)·P.
- R10: Each change of `filt_level` gives exactly one one-cycle pulse, on `rise_pulse` (0→1) or on `fall_pulse` (1→0). The pulse is high in the first cycle that shows the new level. The two pulses never occur together.
- R11: After any register write at edge E, `settled` is 0 until edge E+P×N, and from that edge on it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | 1 | Asynchronous pin to be filtered |
| bus_wr | input | 1 | Byte write strobe for the control register |
| bus_bit_wr | input | 1 | Single-bit write strobe |
| bus_bit_sel | input | 3 | Bit index for a single-bit write |
| bus_wdata | input | 8 | Write data (bit 0 is the value for a single-bit write) |
| bus_rdata | output | 8 | Control register read value |
| filt_level | output | 1 | Filtered pin level |
| rise_pulse | output | 1 | One-cycle pulse on a filtered 0→1 change |
| fall_pulse | output | 1 | One-cycle pulse on a filtered 1→0 change |
| settled | output | 1 | High once the qualification interval after the last write has elapsed |
| cfg_error | output | 1 | Sticky flag: a prohibited rate code was written |

## Verification
On every cycle, the assertions check four things. The filtered level moves only right after a sampling tick. The edge pulses are exclusive and match the level change. The divider count stays below the selected period and is restarted by rate writes. Finally, `settled` drops after a write and `cfg_error` never clears on its own. Only the bench scenarios can show the end-to-end numbers. These are the exact latency from a pin change to the pulse for every rate and count, the widest glitch that is rejected, the settle interval, and the read-back of byte and bit writes, including reserved and prohibited values.

// File: rtl/nf_pkg.sv
package nf_pkg;
  localparam int MAX_DIV     = 64;
  localparam int DIV_W       = $clog2(MAX_DIV) + 1;
  localparam int CNT_W       = $clog2(MAX_DIV);
  localparam int MAX_SAMPLES = 3;
  localparam int SMP_W       = $clog2(MAX_SAMPLES + 1);
  localparam int SETTLE_W    = $clog2(MAX_DIV * MAX_SAMPLES + 1);

  typedef struct packed {
    logic       two_smp;   // bit 6: 1 -> two samples, 0 -> three
    logic [2:0] rate_code; // bits 2:0
  } nf_ctrl_t;

  function automatic logic rate_bad(input logic [2:0] code);
    return code[2] & code[1];
  endfunction

  function automatic logic [DIV_W-1:0] rate_div(input logic [2:0] code);
    case (code)
      3'd1:    return DIV_W'(2);
      3'd2:    return DIV_W'(4);
      3'd3:    return DIV_W'(16);
      3'd4:    return DIV_W'(32);
      3'd5:    return DIV_W'(64);
      default: return DIV_W'(1);
    endcase
  endfunction

  function automatic logic [SMP_W-1:0] smp_need(input logic two_smp);
    return two_smp ? SMP_W'(2) : SMP_W'(3);
  endfunction

  function automatic logic [SETTLE_W-1:0] settle_len(input nf_ctrl_t c);
    return SETTLE_W'(rate_div(c.rate_code)) * SETTLE_W'(smp_need(c.two_smp));
  endfunction
endpackage

// File: rtl/nf_ctrl_reg.sv
module nf_ctrl_reg
  import nf_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           byte_wr,
  input  logic           bit_wr,
  input  logic [2:0]     bit_sel,
  input  logic [7:0]     wdata,
  output nf_ctrl_t       ctrl,
  output logic           cfg_write,
  output logic           rate_write,
  output logic           cfg_error
);
  logic [7:0] view, next_view;

  assign view = {1'b0, ctrl.two_smp, 3'b000, ctrl.rate_code};

  always_comb begin
    next_view = view;
    if (byte_wr)     next_view = wdata;
    else if (bit_wr) next_view[bit_sel] = wdata[0];
  end

  assign cfg_write  = byte_wr | bit_wr;
  assign rate_write = byte_wr | (bit_wr & (bit_sel < 3'd3));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      cfg_error <= 1'b0;
    end else begin
      if (cfg_write) begin
        ctrl.two_smp   <= next_view[6];
        ctrl.rate_code <= next_view[2:0];
      end
      if (cfg_write && rate_bad(next_view[2:0])) cfg_error <= 1'b1;
    end
  end

  assert_error_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_error) |-> cfg_error);
  assert_bad_code_flags_R6: assert property (@(posedge clk) disable iff (rst)
    rate_bad(ctrl.rate_code) |-> cfg_error);
endmodule

// File: rtl/nf_prescaler.sv
module nf_prescaler
  import nf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;

  assign tick = ({1'b0, cnt} == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + CNT_W'(1);
  end

  assert_cnt_in_range_R5: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cnt} < div);
  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> (cnt == '0));
endmodule

// File: rtl/nf_qualifier.sv
module nf_qualifier
  import nf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pin_raw,
  input  logic             tick,
  input  logic [SMP_W-1:0] need,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp;
  logic [SMP_W-1:0]       diff_cnt;
  logic [SMP_W-1:0]       diff_next;
  logic                   flip;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)        sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= pin_raw;
        else            sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign smp       = sync_q[SYNC_STAGES-1];
  assign diff_next = diff_cnt + SMP_W'(1);
  assign flip      = tick && (smp != level) && (diff_next >= need);

  always_ff @(posedge clk) begin
    if (rst) begin
      diff_cnt <= '0;
      level    <= 1'b0;
      rise     <= 1'b0;
      fall     <= 1'b0;
    end else begin
      rise <= flip & smp;
      fall <= flip & ~smp;
      if (flip) begin
        level    <= smp;
        diff_cnt <= '0;
      end else if (tick) begin
        diff_cnt <= (smp != level) ? diff_next : '0;
      end
    end
  end

  assert_level_moves_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(level) |-> $past(tick));
  assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(rise && fall));
  assert_rise_matches_level_R10: assert property (@(posedge clk) disable iff (rst)
    rise |-> (level && !$past(level)));
  assert_fall_matches_level_R10: assert property (@(posedge clk) disable iff (rst)
    fall |-> (!level && $past(level)));
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    diff_cnt < need || $past(need) != need);
endmodule

// File: rtl/nf_settle.sv
module nf_settle
  import nf_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic [SETTLE_W-1:0] limit,
  output logic                settled
);
  logic [SETTLE_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cyc     <= '0;
      settled <= 1'b0;
    end else if (!settled) begin
      cyc <= cyc + SETTLE_W'(1);
      if (cyc + SETTLE_W'(1) >= limit) settled <= 1'b1;
    end
  end

  assert_write_unsettles_R11: assert property (@(posedge clk) disable iff (rst)
    $past(restart) |-> !settled);
  assert_settled_holds_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(settled) && !$past(restart)) |-> settled);
endmodule

// File: rtl/pin_noise_filter.sv
module pin_noise_filter
  import nf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_raw,
  input  logic       bus_wr,
  input  logic       bus_bit_wr,
  input  logic [2:0] bus_bit_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       filt_level,
  output logic       rise_pulse,
  output logic       fall_pulse,
  output logic       settled,
  output logic       cfg_error
);
  nf_ctrl_t ctrl;
  logic     cfg_write;
  logic     rate_write;
  logic     smp_tick;

  nf_ctrl_reg u_reg (
    .clk(clk), .rst(rst),
    .byte_wr(bus_wr), .bit_wr(bus_bit_wr), .bit_sel(bus_bit_sel), .wdata(bus_wdata),
    .ctrl(ctrl), .cfg_write(cfg_write), .rate_write(rate_write), .cfg_error(cfg_error)
  );

  nf_prescaler u_div (
    .clk(clk), .rst(rst), .restart(rate_write),
    .div(rate_div(ctrl.rate_code)), .tick(smp_tick)
  );

  nf_qualifier #(.SYNC_STAGES(2)) u_qual (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .tick(smp_tick),
    .need(smp_need(ctrl.two_smp)),
    .level(filt_level), .rise(rise_pulse), .fall(fall_pulse)
  );

  nf_settle u_settle (
    .clk(clk), .rst(rst), .restart(cfg_write),
    .limit(settle_len(ctrl)), .settled(settled)
  );

  assign bus_rdata = {1'b0, ctrl.two_smp, 3'b000, ctrl.rate_code};

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr) |-> (bus_rdata == ($past(bus_wdata) & 8'h47)));
endmodule

// File: tb/tb_pin_noise_filter.sv
module tb_pin_noise_filter;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin_raw = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_bit_wr = 1'b0;
  logic [2:0] bus_bit_sel = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       filt_level, rise_pulse, fall_pulse, settled, cfg_error;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_noise_filter dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw),
    .bus_wr(bus_wr), .bus_bit_wr(bus_bit_wr), .bus_bit_sel(bus_bit_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .filt_level(filt_level), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
    .settled(settled), .cfg_error(cfg_error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int code);
    int p = 1;
    if (code >= 1 && code <= 5) p = (code <= 2) ? (1 << code) : (1 << (code + 1));
    return p;
  endfunction

  task automatic byte_write(input logic [7:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bit_write(input int idx, input logic val);
    @(negedge clk);
    bus_bit_wr = 1'b1; bus_bit_sel = 3'(idx); bus_wdata = {7'b0, val};
    @(negedge clk);
    bus_bit_wr = 1'b0;
  endtask

  // write cfg, change pin right after the write edge, measure pulse and settle cycles
  task automatic measure(input logic [7:0] cfg, input logic lvl,
                         output int k_edge, output int k_set);
    int p, n, lim;
    p = period_of(int'(cfg[2:0]));
    n = cfg[6] ? 2 : 3;
    lim = 3 * p * n + 8;
    k_edge = -1; k_set = -1;
    byte_write(cfg);
    pin_raw = lvl;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (k_edge < 0 && (lvl ? rise_pulse : fall_pulse)) begin
        k_edge = k;
        chk(filt_level == lvl, "R10 level with pulse", int'(filt_level), int'(lvl));
      end
      if (k_set < 0 && settled) k_set = k;
    end
  endtask

  task automatic sweep_cfg(input logic [7:0] cfg);
    int p, n, t0, ke, ks, rises;
    p = period_of(int'(cfg[2:0]));
    n = cfg[6] ? 2 : 3;
    t0 = ((3 + p - 1) / p) * p;
    measure(cfg, 1'b1, ke, ks);
    chk(ke == t0 + (n - 1) * p, "R9 rise latency (R4 R5 R7)", ke, t0 + (n - 1) * p);
    chk(ks == p * n, "R11 settle time", ks, p * n);
    measure(cfg, 1'b0, ke, ks);
    chk(ke == t0 + (n - 1) * p, "R9 fall latency (R4 R5 R7)", ke, t0 + (n - 1) * p);
    // R8: glitch of width P*(N-1) is rejected
    byte_write(cfg);
    rises = 0;
    pin_raw = 1'b1;
    for (int k = 0; k < p * (n - 1); k++) begin
      @(negedge clk);
      if (rise_pulse) rises++;
    end
    pin_raw = 1'b0;
    for (int k = 0; k < p * n + 8; k++) begin
      @(negedge clk);
      if (rise_pulse || filt_level) rises++;
    end
    chk(rises == 0, "R8 glitch rejected", rises, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_rdata == 8'h00, "R1 reset rdata", bus_rdata, 0);
    chk(filt_level == 1'b0, "R1 reset level", filt_level, 0);
    chk(!rise_pulse && !fall_pulse, "R1 reset pulses", rise_pulse | fall_pulse, 0);
    chk(cfg_error == 1'b0, "R1 reset error", cfg_error, 0);
    chk(settled == 1'b0, "R1 reset settled", settled, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(settled == 1'b0, "R1 settled before 3 cycles", settled, 0);
    @(negedge clk);
    chk(settled == 1'b1, "R1 settled after 3 cycles", settled, 1);

    for (int c = 0; c < 6; c++) begin
      for (int s = 0; s < 2; s++) begin
        sweep_cfg({1'b0, 1'(s), 3'b000, 3'(c)});
      end
    end
    chk(cfg_error == 1'b0, "R6 no error on legal codes", cfg_error, 0);

    // R3 bit writes
    byte_write(8'h00);
    bit_write(6, 1'b1);
    chk(bus_rdata == 8'h40, "R3 bit 6 set", bus_rdata, 8'h40);
    bit_write(4, 1'b1);
    chk(bus_rdata == 8'h40, "R3 reserved bit ignored", bus_rdata, 8'h40);
    bit_write(1, 1'b1);
    chk(bus_rdata == 8'h42, "R3 bit 1 set", bus_rdata, 8'h42);
    bit_write(6, 1'b0);
    chk(bus_rdata == 8'h02, "R3 bit 6 cleared", bus_rdata, 8'h02);

    // R6 prohibited code behaves as full rate
    begin
      int ke, ks;
      measure(8'h06, 1'b1, ke, ks);
      chk(ke == 5, "R6 code 6 rise latency", ke, 5);
      chk(ks == 3, "R6 code 6 settle", ks, 3);
      chk(cfg_error == 1'b1, "R6 error set", cfg_error, 1);
      chk(bus_rdata == 8'h06, "R6 code reads back", bus_rdata, 8'h06);
      measure(8'h00, 1'b0, ke, ks);
    end
    byte_write(8'hFF);
    chk(bus_rdata == 8'h47, "R2 reserved bits read zero", bus_rdata, 8'h47);
    byte_write(8'h00);
    chk(bus_rdata == 8'h00, "R2 byte write clears", bus_rdata, 0);
    chk(cfg_error == 1'b1, "R6 error sticky", cfg_error, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule